// File: doc/BRIEF.md
# Dual Alarm Interrupt Comparator

This block keeps two alarm settings and compares each against the running time of day. It takes the current weekday, hour and minute from an external timekeeping chain, plus a one-cycle strobe that marks each minute rollover. The comparison is made only on that strobe.

The weekly alarm fires when the hour and minute agree with its settings and the current weekday is one of the days selected in its day mask. The daily alarm looks at hour and minute alone. A hit sets a sticky flag for that alarm. Each flag drives its own active-low interrupt line, and the line stays low until software clears the flag through the register port. Software uses the same write-only port to program the fields and the enables.

Top module: `dual_alarm_cmp`

## Requirements
- R1: With the weekly alarm enabled, a minute strobe whose hour (BCD) and minute (BCD) equal the weekly settings and whose weekday is selected in the mask sets `weeklyFlag` and drives `intWeeklyN` low on the following clock edge. A mismatch in hour or minute sets nothing.
- R2: With the daily alarm enabled, a minute strobe whose hour and minute equal the daily settings sets `dailyFlag` and drives `intDailyN` low, whatever the weekday.
- R3: Both interrupt lines are active low. They are high, and both flags are 0, after reset and whenever the matching flag is clear.
- R4: The weekly day mask has bit d set to select weekday value d (0 to 6). A weekday value of 7 never matches.
- R5: Control register bit 0 enables the weekly alarm and bit 1 enables the daily alarm. Both enables are 0 after reset. A disabled alarm never sets its flag. Writing 0 to an enable bit clears that alarm's flag.
- R6: Matches are evaluated only in cycles where `minTick` is 1. Once set, a flag holds until it is cleared, even across non-matching strobes.
- R7: Writing the clear register with bit 0 or bit 1 set clears the weekly or daily flag. A cleared flag stays clear until the next matching strobe. If a clear and a matching strobe occur in the same cycle, the flag is set.
- R8: Register addresses: 0 weekly minute, 1 weekly hour, 2 weekly day mask, 3 daily minute, 4 daily hour, 5 control, 6 flag clear. All settings reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Register write data |
| minTick | input | 1 | One-cycle strobe at each minute rollover |
| curDay | input | 3 | Current weekday, 0 to 6 |
| curHour | input | 6 | Current hour, BCD |
| curMin | input | 7 | Current minute, BCD |
| weeklyFlag | output | 1 | Sticky weekly match flag |
| dailyFlag | output | 1 | Sticky daily match flag |
| intWeeklyN | output | 1 | Weekly interrupt, active low |
| intDailyN | output | 1 | Daily interrupt, active low |

## Verification
The bench checks weekday selection at the edges of the mask and with an out-of-range weekday value. A design that indexed the mask wrongly would fire on the wrong day or on value 7. It holds a matching time with the strobe low to catch a comparator that runs every cycle, and it clears a flag with no new strobe to catch a design that re-sets from a stale match. It also drives a clear and a matching strobe in the same cycle, and disables an alarm whose flag is set. Wrong priority or a missing enable gate in either case shows up as a pin at the wrong level.

// File: rtl/dual_alarm_pkg.sv
package dual_alarm_pkg;

  localparam int ADR_WK_MIN  = 0;
  localparam int ADR_WK_HOUR = 1;
  localparam int ADR_WK_DAYS = 2;
  localparam int ADR_DY_MIN  = 3;
  localparam int ADR_DY_HOUR = 4;
  localparam int ADR_CTRL    = 5;
  localparam int ADR_CLR     = 6;

  localparam int ALARM_N = 2;
  localparam int IDX_WK  = 0;
  localparam int IDX_DY  = 1;

  typedef struct packed {
    logic ldWkMin;
    logic ldWkHour;
    logic ldWkDays;
    logic ldDyMin;
    logic ldDyHour;
    logic ldCtrl;
    logic [ALARM_N-1:0] clr;
    logic eval;
  } alarm_strobe_t;

endpackage

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import dual_alarm_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              minTick,
  output alarm_strobe_t     strobe
);

  function automatic logic hitAddr(input logic [ADDR_W-1:0] a, input int target);
    return a == ADDR_W'(target);
  endfunction

  always_comb begin
    strobe          = '0;
    strobe.eval     = minTick;
    strobe.ldWkMin  = regWrEn && hitAddr(regAddr, ADR_WK_MIN);
    strobe.ldWkHour = regWrEn && hitAddr(regAddr, ADR_WK_HOUR);
    strobe.ldWkDays = regWrEn && hitAddr(regAddr, ADR_WK_DAYS);
    strobe.ldDyMin  = regWrEn && hitAddr(regAddr, ADR_DY_MIN);
    strobe.ldDyHour = regWrEn && hitAddr(regAddr, ADR_DY_HOUR);
    strobe.ldCtrl   = regWrEn && hitAddr(regAddr, ADR_CTRL);
    for (int i = 0; i < ALARM_N; i++) begin
      strobe.clr[i] = regWrEn && hitAddr(regAddr, ADR_CLR) && regWrData[i];
    end
  end

endmodule

// File: rtl/alarm_datapath.sv
module alarm_datapath
  import dual_alarm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MIN_W  = 7,
  parameter int HOUR_W = 6,
  parameter int DAY_W  = 3,
  parameter int DAY_N  = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  alarm_strobe_t      strobe,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [DAY_W-1:0]   curDay,
  input  logic [HOUR_W-1:0]  curHour,
  input  logic [MIN_W-1:0]   curMin,
  output logic [ALARM_N-1:0] flag
);

  logic [MIN_W-1:0]   wkMin, dyMin;
  logic [HOUR_W-1:0]  wkHour, dyHour;
  logic [DAY_N-1:0]   wkDays;
  logic [ALARM_N-1:0] enable;
  logic [ALARM_N-1:0] hit;
  logic               dayHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wkMin  <= '0;
      wkHour <= '0;
      wkDays <= '0;
      dyMin  <= '0;
      dyHour <= '0;
      enable <= '0;
    end else begin
      if (strobe.ldWkMin)  wkMin  <= wrData[MIN_W-1:0];
      if (strobe.ldWkHour) wkHour <= wrData[HOUR_W-1:0];
      if (strobe.ldWkDays) wkDays <= wrData[DAY_N-1:0];
      if (strobe.ldDyMin)  dyMin  <= wrData[MIN_W-1:0];
      if (strobe.ldDyHour) dyHour <= wrData[HOUR_W-1:0];
      if (strobe.ldCtrl)   enable <= wrData[ALARM_N-1:0];
    end
  end

  always_comb begin
    dayHit = 1'b0;
    for (int d = 0; d < DAY_N; d++) begin
      if (curDay == DAY_W'(d)) dayHit = wkDays[d];
    end
  end

  assign hit[IDX_WK] = dayHit && (curHour == wkHour) && (curMin == wkMin);
  assign hit[IDX_DY] = (curHour == dyHour) && (curMin == dyMin);

  for (genvar i = 0; i < ALARM_N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flag[i] <= 1'b0;
      end else if (strobe.ldCtrl && !wrData[i]) begin
        flag[i] <= 1'b0;
      end else if (strobe.eval && enable[i] && hit[i]) begin
        flag[i] <= 1'b1;
      end else if (strobe.clr[i]) begin
        flag[i] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dual_alarm_cmp.sv
module dual_alarm_cmp
  import dual_alarm_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int MIN_W  = 7,
  parameter int HOUR_W = 6,
  parameter int DAY_W  = 3,
  parameter int DAY_N  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              minTick,
  input  logic [DAY_W-1:0]  curDay,
  input  logic [HOUR_W-1:0] curHour,
  input  logic [MIN_W-1:0]  curMin,
  output logic              weeklyFlag,
  output logic              dailyFlag,
  output logic              intWeeklyN,
  output logic              intDailyN
);

  alarm_strobe_t      strobe;
  logic [ALARM_N-1:0] flag;

  alarm_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .minTick   (minTick),
    .strobe    (strobe)
  );

  alarm_datapath #(
    .DATA_W(DATA_W), .MIN_W(MIN_W), .HOUR_W(HOUR_W), .DAY_W(DAY_W), .DAY_N(DAY_N)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (regWrData),
    .curDay  (curDay),
    .curHour (curHour),
    .curMin  (curMin),
    .flag    (flag)
  );

  assign weeklyFlag = flag[IDX_WK];
  assign dailyFlag  = flag[IDX_DY];
  assign intWeeklyN = ~flag[IDX_WK];
  assign intDailyN  = ~flag[IDX_DY];

endmodule

// File: rtl/dual_alarm_cmp_chk.sv
module dual_alarm_cmp_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int DAY_W  = 3,
  parameter int DAY_N  = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic              minTick,
  input logic [DAY_W-1:0]  curDay,
  input logic              weeklyFlag,
  input logic              dailyFlag,
  input logic              intWeeklyN,
  input logic              intDailyN
);
  import dual_alarm_pkg::*;

  logic wrClr, wrCtrl;
  assign wrClr  = regWrEn && (regAddr == ADDR_W'(ADR_CLR));
  assign wrCtrl = regWrEn && (regAddr == ADDR_W'(ADR_CTRL));

  p_weekly_on_tick_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(weeklyFlag) |-> $past(minTick));

  p_daily_pin_on_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intDailyN) |-> $past(minTick));

  p_weekly_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    weeklyFlag && !wrClr && !wrCtrl |=> weeklyFlag);

  p_daily_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    dailyFlag && !wrClr && !wrCtrl |=> dailyFlag);

  p_weekly_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrClr && regWrData[0] && !minTick |=> !weeklyFlag);

  p_daily_disable_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl && !regWrData[1] |=> !dailyFlag);

  p_day_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(weeklyFlag) |-> ($past(curDay) < DAY_W'(DAY_N)));

endmodule

bind dual_alarm_cmp dual_alarm_cmp_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DAY_W(DAY_W), .DAY_N(DAY_N)
) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .minTick(minTick), .curDay(curDay),
  .weeklyFlag(weeklyFlag), .dailyFlag(dailyFlag),
  .intWeeklyN(intWeeklyN), .intDailyN(intDailyN)
);

// File: tb/dual_alarm_cmp_test.sv
module dual_alarm_cmp_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic       minTick = 1'b0;
  logic [2:0] curDay = '0;
  logic [5:0] curHour = '0;
  logic [6:0] curMin = '0;
  logic       weeklyFlag, dailyFlag, intWeeklyN, intDailyN;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_alarm_cmp uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .minTick(minTick), .curDay(curDay),
    .curHour(curHour), .curMin(curMin), .weeklyFlag(weeklyFlag),
    .dailyFlag(dailyFlag), .intWeeklyN(intWeeklyN), .intDailyN(intDailyN)
  );

  task automatic expectState(input bit wk, input bit dy, input string tag);
    checks++;
    if (weeklyFlag !== wk || dailyFlag !== dy || intWeeklyN !== !wk || intDailyN !== !dy) begin
      errors++;
      $display("FAIL %s: flags wk=%0b dy=%0b pins B=%0b C=%0b, expected flags wk=%0b dy=%0b pins B=%0b C=%0b",
               tag, weeklyFlag, dailyFlag, intWeeklyN, intDailyN, wk, dy, !wk, !dy);
    end
  endtask

  task automatic writeReg(input int addr, input logic [7:0] data);
    regWrEn = 1'b1; regAddr = 3'(addr); regWrData = data;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic tickAt(input logic [2:0] d, input logic [5:0] h, input logic [6:0] m);
    curDay = d; curHour = h; curMin = m; minTick = 1'b1;
    @(posedge clk); @(negedge clk);
    minTick = 1'b0;
  endtask

  task automatic setupAlarms();
    writeReg(0, 8'h30); writeReg(1, 8'h08); writeReg(2, 8'b0000100);
    writeReg(3, 8'h45); writeReg(4, 8'h17); writeReg(5, 8'h03);
  endtask

  task automatic testReset();
    expectState(0, 0, "R3 reset state");
  endtask

  task automatic testWeeklyMatch();
    tickAt(3'd2, 6'h08, 7'h30);
    expectState(1, 0, "R1 weekly match day2 08:30");
    writeReg(6, 8'h01);
    expectState(0, 0, "R7 weekly clear");
    tickAt(3'd2, 6'h08, 7'h31);
    expectState(0, 0, "R1 minute mismatch");
    tickAt(3'd2, 6'h09, 7'h30);
    expectState(0, 0, "R1 hour mismatch");
    tickAt(3'd3, 6'h08, 7'h30);
    expectState(0, 0, "R4 day not in mask");
  endtask

  task automatic testDaily();
    tickAt(3'd0, 6'h17, 7'h45);
    expectState(0, 1, "R2 daily match day0");
    writeReg(6, 8'h02);
    expectState(0, 0, "R7 daily clear");
    tickAt(3'd5, 6'h17, 7'h45);
    expectState(0, 1, "R2 daily match day5");
    writeReg(6, 8'h02);
  endtask

  task automatic testMask();
    writeReg(2, 8'b1000001);
    tickAt(3'd6, 6'h08, 7'h30);
    expectState(1, 0, "R4 mask bit6 day6");
    writeReg(6, 8'h01);
    tickAt(3'd0, 6'h08, 7'h30);
    expectState(1, 0, "R4 mask bit0 day0");
    writeReg(6, 8'h01);
    tickAt(3'd7, 6'h08, 7'h30);
    expectState(0, 0, "R4 day value 7 never matches");
    writeReg(2, 8'h7F);
    tickAt(3'd7, 6'h08, 7'h30);
    expectState(0, 0, "R4 day 7 with full mask");
  endtask

  task automatic testTickAndSticky();
    curDay = 3'd3; curHour = 6'h08; curMin = 7'h30;
    repeat (4) @(negedge clk);
    expectState(0, 0, "R6 no evaluation without tick");
    tickAt(3'd3, 6'h08, 7'h30);
    expectState(1, 0, "R6 tick evaluates");
    tickAt(3'd3, 6'h11, 7'h00);
    repeat (3) @(negedge clk);
    expectState(1, 0, "R6 flag sticky over nonmatching tick");
    writeReg(6, 8'h01);
    curDay = 3'd3; curHour = 6'h08; curMin = 7'h30;
    repeat (5) @(negedge clk);
    expectState(0, 0, "R7 no retrigger in same minute");
    tickAt(3'd3, 6'h08, 7'h30);
    expectState(1, 0, "R7 retrigger on next matching tick");
    writeReg(6, 8'h01);
  endtask

  task automatic testSameCycle();
    curDay = 3'd4; curHour = 6'h08; curMin = 7'h30;
    regWrEn = 1'b1; regAddr = 3'd6; regWrData = 8'h01; minTick = 1'b1;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0; minTick = 1'b0;
    expectState(1, 0, "R7 set wins over same-cycle clear");
    writeReg(6, 8'h01);
  endtask

  task automatic testEnable();
    writeReg(5, 8'h02);
    tickAt(3'd4, 6'h08, 7'h30);
    expectState(0, 0, "R5 disabled weekly does not set");
    tickAt(3'd1, 6'h17, 7'h45);
    expectState(0, 1, "R5 daily still enabled");
    writeReg(5, 8'h01);
    expectState(0, 0, "R5 disabling clears daily flag");
    tickAt(3'd1, 6'h17, 7'h45);
    expectState(0, 0, "R5 disabled daily does not set");
  endtask

  task automatic testRegMap();
    writeReg(5, 8'h03);
    writeReg(3, 8'h59); writeReg(4, 8'h23);
    tickAt(3'd1, 6'h17, 7'h45);
    expectState(0, 0, "R8 old daily time no longer matches");
    tickAt(3'd1, 6'h23, 7'h59);
    expectState(0, 1, "R8 daily fields at addr 3 and 4");
    writeReg(0, 8'h00); writeReg(1, 8'h00);
    tickAt(3'd2, 6'h00, 7'h00);
    expectState(1, 1, "R8 weekly fields at addr 0 and 1");
    writeReg(6, 8'h03);
    expectState(0, 0, "R7 clear both flags");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    setupAlarms();
    expectState(0, 0, "R3 pins high after setup");
    testWeeklyMatch();
    testDaily();
    testMask();
    testTickAndSticky();
    testSameCycle();
    testEnable();
    testRegMap();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule